// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the 16x oversampling strobe for a serial receiver and transmitter from the system clock. The wanted divisor is the clock frequency over sixteen times the baud rate. It arrives as two values: a 12-bit whole part, and a 7-bit fraction that counts in steps of 1/128 of a clock cycle. The output is a one-cycle strobe. Most strobe periods last exactly the whole part. Some last one cycle more, and these are chosen by a running fraction accumulator, so over time the average period equals whole + fraction/128. The stretched periods are spread evenly rather than grouped together.

Both divisor values are plain inputs, driven from a configuration register elsewhere. Any change to either value restarts the generator cleanly. A whole part of zero parks it, and no strobes are produced.

Top module: `frac_baud_tick`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `os_tick` is 0 after that edge.
- R2: With `div_whole` = 1 and `div_frac` = 0, `os_tick` is high on every cycle. With `div_whole` greater than 1, `os_tick` is never high on two consecutive cycles.
- R3: While `div_whole` is 0, `os_tick` stays low whatever `div_frac` holds.
- R4: Each strobe period is `div_whole` cycles plus the carry out of a 7-bit accumulator. The accumulator adds `div_frac` once at every strobe, and the carry of that addition lengthens the following period by one cycle. The first period after a restart is never lengthened.
- R5: With the divisor held steady, any 128 consecutive strobe periods, excluding the first period after a restart, total exactly 128 × `div_whole` + `div_frac` cycles.
- R6: A change to either `div_whole` or `div_frac` clears the period counter and the accumulator, and forces `os_tick` low on the next cycle. The first strobe after the change is high in the cycle that follows the (`div_whole`+1)-th rising edge counted from the change, where the first edge is the one that samples the new value.
- R7: With `div_frac` = 0, every strobe period is exactly `div_whole` cycles, up to the largest value 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_whole | input | 12 | Whole part of the divisor, in clock cycles |
| div_frac | input | 7 | Fractional part of the divisor, in 1/128 cycle steps |
| os_tick | output | 1 | One-cycle oversampling strobe |

## Verification
The bench aims at the carry placement of the accumulator. A fraction that is added one tick late, or that lengthens the period it is computed in instead of the next one, shifts every strobe after the first carry. A generator that kept its accumulator across a restart would stretch the first period, and this is exercised by changing only the fraction in the middle of a period. The extremes are also covered. A whole part of 1 must produce a strobe on every cycle. A whole part of 4095 with a carry must give a 4096-cycle period, and a counter one bit too narrow would wrap there. A zero whole part must stay silent, so an off-by-one compare that underflows would show up as stray strobes.

// File: rtl/frac_baud_pkg.sv
// Shared sizing for the fractional baud tick generator.
// Assumes the oversampling factor (16) is already folded into the divisor.
package frac_baud_pkg;
    parameter int WHOLE_W = 12;  // bits of the whole divisor part
    parameter int FRAC_W  = 7;   // bits of the fraction (steps of 1/2**FRAC_W)
endpackage

// File: rtl/baud_div_track.sv
// Divisor change tracker.
// Registers the divisor seen on the previous cycle and flags a restart
// whenever either part differs from it. Assumes reset value 0 for both,
// so a nonzero divisor present at reset release also triggers a restart.
module baud_div_track #(
    parameter int IW = frac_baud_pkg::WHOLE_W,
    parameter int FW = frac_baud_pkg::FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] div_whole,
    input  logic [FW-1:0] div_frac,
    output logic          restart
);
    logic [IW-1:0] whole_q;
    logic [FW-1:0] frac_q;

    // Remember last cycle's divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            whole_q <= '0;
            frac_q  <= '0;
        end else begin
            whole_q <= div_whole;
            frac_q  <= div_frac;
        end
    end

    // Any difference from last cycle requests a restart.
    always_comb restart = (div_whole != whole_q) || (div_frac != frac_q);
endmodule

// File: rtl/baud_frac_acc.sv
// Fraction accumulator.
// Adds the fraction once per strobe; the carry out becomes the stretch
// flag that lengthens the next period by one cycle. Assumes 'clear' has
// priority over 'advance'.
module baud_frac_acc #(
    parameter int FW = frac_baud_pkg::FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic [FW-1:0] div_frac,
    output logic          stretch
);
    logic [FW-1:0] acc_q;
    logic [FW:0]   sum;

    // Wide sum keeps the carry as its top bit.
    always_comb sum = {1'b0, acc_q} + {1'b0, div_frac};

    // Update the phase and latch the carry at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q   <= '0;
            stretch <= 1'b0;
        end else if (advance) begin
            acc_q   <= sum[FW-1:0];
            stretch <= sum[FW];
        end
    end
endmodule

// File: rtl/baud_period_cnt.sv
// Period counter.
// Counts cycles from 0 up to whole + stretch - 1, then fires and wraps.
// The strobe is registered, so it appears the cycle after 'fire'.
// Assumes a whole part of 0 means stopped.
module baud_period_cnt #(
    parameter int IW = frac_baud_pkg::WHOLE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [IW-1:0] div_whole,
    input  logic          stretch,
    output logic          fire,
    output logic          tick
);
    localparam logic [IW:0] ONE = (IW+1)'(1);

    logic [IW-1:0] cnt_q;
    logic [IW:0]   last_cnt;
    logic          running;

    // Terminal count of the current period.
    always_comb last_cnt = {1'b0, div_whole} + {{IW{1'b0}}, stretch} - ONE;

    // Count only with a nonzero divisor and no restart pending.
    always_comb running = (div_whole != '0) && !clear;

    // Period end reached.
    always_comb fire = running && ({1'b0, cnt_q} == last_cnt);

    // Advance the counter and register the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (fire) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/frac_baud_tick.sv
// Fractional baud tick generator, top level.
// Produces a one-cycle oversampling strobe whose average period is
// div_whole + div_frac / 2**FW clock cycles. Assumes the divisor is
// quasi-static; every change restarts the sequence from a clean phase.
module frac_baud_tick #(
    parameter int IW = frac_baud_pkg::WHOLE_W,
    parameter int FW = frac_baud_pkg::FRAC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] div_whole,
    input  logic [FW-1:0] div_frac,
    output logic          os_tick
);
    logic restart;
    logic stretch;
    logic fire;

    baud_div_track #(.IW(IW), .FW(FW)) track_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_whole (div_whole),
        .div_frac  (div_frac),
        .restart   (restart)
    );

    baud_frac_acc #(.FW(FW)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .advance  (fire),
        .div_frac (div_frac),
        .stretch  (stretch)
    );

    baud_period_cnt #(.IW(IW)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (restart),
        .div_whole (div_whole),
        .stretch   (stretch),
        .fire      (fire),
        .tick      (os_tick)
    );
endmodule

// File: rtl/frac_baud_tick_chk.sv
// Property checker for frac_baud_tick, attached through bind.
// Observes ports only; 'seen' marks that one cycle out of reset has passed
// so that $past never looks at pre-reset values.
module frac_baud_tick_chk #(
    parameter int IW = frac_baud_pkg::WHOLE_W,
    parameter int FW = frac_baud_pkg::FRAC_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [IW-1:0] div_whole,
    input logic [FW-1:0] div_frac,
    input logic          os_tick
);
    logic seen;

    // Track one full cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !os_tick);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && div_whole > IW'(1)) |=> !os_tick);

    // R3
    zero_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_whole == '0) |=> !os_tick);

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && (div_whole != $past(div_whole) || div_frac != $past(div_frac)))
        |=> !os_tick);
endmodule

bind frac_baud_tick frac_baud_tick_chk #(.IW(IW), .FW(FW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_whole (div_whole),
    .div_frac  (div_frac),
    .os_tick   (os_tick)
);

// File: tb/frac_baud_tick_tb_top.sv
// Scoreboard bench: the driver predicts strobe cycles into a queue,
// the monitor pops and compares them as strobes appear.
module frac_baud_tick_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] div_whole = '0;
    logic [6:0]  div_frac = '0;
    logic        os_tick;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    string cur_req = "R1";
    int exp_q[$];
    int obs_q[$];

    frac_baud_tick dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_whole (div_whole),
        .div_frac  (div_frac),
        .os_tick   (os_tick)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each observed strobe with the predicted cycle.
    always @(negedge clk) begin
        if (rst_n && os_tick) begin
            obs_q.push_back(cyc);
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: unexpected strobe at cycle %0d, expected none", cur_req, cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (cyc != e) begin
                    fails++;
                    $display("FAIL %s: strobe at cycle %0d, expected %0d", cur_req, cyc, e);
                end
            end
        end
    end

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    // Driver: wait d cycles, apply a divisor, predict n strobes, wait for them.
    task automatic program_div(int w, int f, int n, int d, string req);
        int t;
        repeat (d) @(negedge clk);
        #1;
        div_whole = 12'(w);
        div_frac  = 7'(f);
        cur_req   = req;
        obs_q.delete();
        exp_q.delete();
        t = cyc + 1 + w;
        if (n == 0) begin
            repeat (60) @(negedge clk);
            #1;
            check_eq({req, " no strobe with zero whole"}, obs_q.size(), 0);
            return;
        end
        exp_q.push_back(t);
        for (int k = 1; k < n; k++) begin
            t += w + ((k * f) / 128) - (((k - 1) * f) / 128);
            exp_q.push_back(t);
        end
        while (cyc < t) @(negedge clk);
        #1;
        check_eq({req, " strobe count"}, obs_q.size(), n);
        if (n >= 129 && obs_q.size() >= 129)
            check_eq("R5 span 1..128", obs_q[128] - obs_q[0], 128 * w + f);
        if (n >= 137 && obs_q.size() >= 137)
            check_eq("R5 span 9..136", obs_q[136] - obs_q[8], 128 * w + f);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run incomplete at cycle %0d, expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: strobe held low during reset even with a live divisor.
        div_whole = 12'd3;
        div_frac  = 7'd5;
        repeat (6) begin
            @(negedge clk);
            check_eq("R1 quiet in reset", int'(os_tick), 0);
        end
        #1;
        div_whole = '0;
        div_frac  = '0;
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        program_div(4, 0, 10, 0, "R7");        // plain integer period
        program_div(1, 0, 20, 0, "R2");        // strobe on every cycle
        program_div(3, 37, 140, 0, "R4");      // dithered periods
        program_div(2, 127, 140, 0, "R5");     // nearly every period stretched
        program_div(5, 1, 140, 1, "R6");       // whole change mid-period
        program_div(5, 64, 20, 2, "R6");       // fraction-only change mid-period
        program_div(0, 90, 0, 0, "R3");        // parked
        program_div(6, 100, 30, 0, "R6");      // restart from parked
        program_div(4095, 0, 2, 0, "R7");      // largest whole part
        program_div(4095, 127, 3, 0, "R4");    // stretch at largest whole part

        #1;
        div_whole = '0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule